// File: doc/BRIEF.md
# Six-Level Return Address Stack

This block keeps subroutine and interrupt return addresses for a small processor core. It is a last-in, first-out store of six 12-bit registers. The registers form a physical shift chain, so there is no pointer. It lives outside data memory. A push moves every entry up one place and writes the new address into the first level. A pop hands the first level to the caller in the same cycle and moves every entry down one place. The program counter logic that uses the returned address is not part of this block.

The stack saturates without any error signal at both ends. When all six levels are occupied, a seventh push drops the oldest address off the far end. A pop on an empty stack changes nothing and reports that no address came back, so the caller falls through to the next sequential address. An internal occupancy count from zero to six decides whether a pop is valid. If a push and a pop arrive in the same cycle on a non-empty stack, the first level is returned and replaced, and the occupancy does not change.

Top module: `ret_stack6`

## Requirements
- R1: After reset the stack is empty: a pop in the first cycle after reset returns pop_valid_o low.
- R2: A pop on a non-empty stack drives pop_valid_o high in the same cycle. pop_addr_o then carries the most recently pushed address that has not yet been popped, so entries come back in reverse order of pushing.
- R3: A pop on an empty stack drives pop_valid_o low and leaves the stack unchanged. A following push and pop return the pushed value, and the pop after that is again invalid.
- R4: Pushes beyond six entries keep only the six newest addresses. The oldest address is lost, and six pops return the six newest addresses, newest first.
- R5: pop_valid_o is high only in a cycle where pop_i is high and the stack holds at least one entry.
- R6: push_i and pop_i together on a non-empty stack return the current first level with pop_valid_o high, write push_addr_i into the first level, and leave the occupancy unchanged.
- R7: push_i and pop_i together on an empty stack return pop_valid_o low, and the push takes effect as a plain push.
- R8: pop_addr_o is all zeros in every cycle where pop_valid_o is low.
- R9: The occupancy never leaves the range 0 to 6 and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Store push_addr_i on top of the stack this cycle |
| pop_i | input | 1 | Take the top entry off the stack this cycle |
| push_addr_i | input | 12 | Return address to be stored |
| pop_addr_o | output | 12 | Top entry, valid in the same cycle as the pop |
| pop_valid_o | output | 1 | High when the current pop returns an address |

## Verification
The bench pushes more than six addresses. A design that lost the wrong end of the chain, or let the occupancy pass six, would return an old address or report a seventh valid pop. It pops an empty stack several times in a row. A count that wrapped below zero would then show valid pops of stale data, and a chain that shifted on an empty pop would corrupt later results. It also issues push and pop together on an empty, a partly filled and a full stack. An implementation that treated the pair as two sequential operations would either return the new address or change the depth, and this shows up in the order and the number of later valid pops.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } rstk_op_e;

  // Resolve the request pair into one chain operation. A pop on an empty
  // stack is dropped, so a simultaneous push on empty becomes a plain push.
  function automatic rstk_op_e decode_op(input logic push, input logic pop,
                                         input logic empty);
    if (push && pop && !empty) return OP_SWAP;
    if (push)                  return OP_PUSH;
    if (pop && !empty)         return OP_POP;
    return OP_HOLD;
  endfunction

  // Occupancy after one operation, saturating at both ends.
  function automatic int unsigned next_fill(input int unsigned fill,
                                            input rstk_op_e op,
                                            input int unsigned depth);
    case (op)
      OP_PUSH: return (fill >= depth) ? depth : fill + 1;
      OP_POP:  return (fill == 0) ? 0 : fill - 1;
      default: return fill;
    endcase
  endfunction

endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output rstk_op_e      op_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] fill_o
);

  localparam logic [CW-1:0] FILL_MAX = CW'(DEPTH);

  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_d;
  rstk_op_e      op;

  assign empty_o = (fill_q == '0);
  assign full_o  = (fill_q == FILL_MAX);
  assign op      = decode_op(push_i, pop_i, empty_o);
  assign op_o    = op;
  assign fill_d  = CW'(next_fill(32'(fill_q), op, 32'(DEPTH)));
  assign fill_o  = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  // R9: occupancy stays inside 0..DEPTH
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX);

  // R9: occupancy moves by at most one per cycle
  p_fill_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == $past(fill_q)) || (fill_q == $past(fill_q) + 1'b1) ||
    (fill_q + 1'b1 == $past(fill_q)));

  // R3: a lone pop on an empty stack leaves the occupancy at zero
  p_empty_pop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> empty_o);

  // R4: a push onto a full stack keeps it full
  p_full_push_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> full_o);

  // R6: a simultaneous push and pop on a non-empty stack keeps the depth
  p_swap_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty_o) |=> $stable(fill_q));

  // R7: a simultaneous push and pop on an empty stack leaves one entry
  p_swap_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && empty_o) |=> (fill_q == CW'(1)));

endmodule

// File: rtl/rstk_level.sv
module rstk_level
  import rstk_pkg::*;
#(
  parameter int AW       = 12,
  parameter bit IS_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rstk_op_e      op_i,
  input  logic [AW-1:0] below_i,
  input  logic [AW-1:0] above_i,
  output logic [AW-1:0] q_o
);

  logic [AW-1:0] q;
  logic [AW-1:0] d;

  generate
    if (IS_FIRST) begin : g_first
      // First level: a swap replaces the entry with the incoming address.
      always_comb begin
        case (op_i)
          OP_PUSH, OP_SWAP: d = below_i;
          OP_POP:           d = above_i;
          default:          d = q;
        endcase
      end
    end else begin : g_inner
      // Other levels: a swap does not touch them.
      always_comb begin
        case (op_i)
          OP_PUSH: d = below_i;
          OP_POP:  d = above_i;
          default: d = q;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign q_o = q;

  // R2: every push moves the neighbour below into this level
  p_push_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH) |=> (q == $past(below_i)));

  // R3: a hold leaves the level untouched
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(q));

endmodule

// File: rtl/ret_stack6.sv
module ret_stack6
  import rstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] pop_addr_o,
  output logic          pop_valid_o
);

  localparam int CW = $clog2(DEPTH + 1);

  rstk_op_e      op;
  logic          empty;
  logic          full;
  logic [CW-1:0] fill;
  logic [AW-1:0] lvl [DEPTH];

  // Named events for the assertions
  logic ev_pop_ok;
  logic ev_pop_empty;
  logic ev_overflow;
  logic ev_swap;

  rstk_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .op_o    (op),
    .empty_o (empty),
    .full_o  (full),
    .fill_o  (fill)
  );

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      logic [AW-1:0] below;
      logic [AW-1:0] above;
      if (i == 0) begin : g_b0
        assign below = push_addr_i;
      end else begin : g_bn
        assign below = lvl[i-1];
      end
      if (i == DEPTH - 1) begin : g_alast
        // The last level keeps its own value when the chain moves down.
        assign above = lvl[i];
      end else begin : g_an
        assign above = lvl[i+1];
      end
      rstk_level #(.AW(AW), .IS_FIRST(i == 0)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .below_i (below),
        .above_i (above),
        .q_o     (lvl[i])
      );
    end
  endgenerate

  assign ev_pop_ok    = pop_i & ~empty;
  assign ev_pop_empty = pop_i & empty;
  assign ev_overflow  = push_i & ~pop_i & full;
  assign ev_swap      = (op == OP_SWAP);

  assign pop_valid_o = ev_pop_ok;
  assign pop_addr_o  = ev_pop_ok ? lvl[0] : '0;

  // R5: a valid pop needs a pop request
  p_valid_needs_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid_o |-> pop_i);

  // R8: no address leaks out without a valid pop
  p_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid_o |-> (pop_addr_o == '0));

  // R3: an empty pop reports nothing
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_empty |-> !pop_valid_o);

  // R6: after a swap the first level holds the incoming address
  p_swap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> (lvl[0] == $past(push_addr_i)));

  // R4: an overflowing push still lands the new address in level one
  p_overflow_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (lvl[0] == $past(push_addr_i)));

  // R9: the stack is never full and empty at once
  p_not_full_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty) && (fill <= CW'(DEPTH)));

endmodule

// File: tb/test_ret_stack6.sv
`timescale 1ns/1ps
module test_ret_stack6;

  localparam int DEPTH = 6;
  localparam int AW    = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;
  logic          pop_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference: front of the queue is the top of the stack
  logic [AW-1:0] model [$];

  always #4 clk = ~clk;

  ret_stack6 #(.DEPTH(DEPTH), .AW(AW)) i_ret_stack6 (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .pop_addr_o  (pop_addr_o),
    .pop_valid_o (pop_valid_o)
  );

  task automatic check(input string req, input logic [AW:0] act,
                       input logic [AW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid=%0b addr=%03h expected valid=%0b addr=%03h",
               req, act[AW], act[AW-1:0], exp[AW], exp[AW-1:0]);
    end
  endtask

  // One cycle of stimulus, checked against the reference before the edge.
  task automatic step(input logic ps, input logic pp, input logic [AW-1:0] d,
                      input string req);
    logic          ev;
    logic [AW-1:0] ea;
    @(negedge clk);
    push_i = ps; pop_i = pp; push_addr_i = d;
    ev = pp && (model.size() > 0);
    ea = ev ? model[0] : '0;
    #1;
    check(req, {pop_valid_o, pop_addr_o}, {ev, ea});
    if (ev && ps) begin
      model[0] = d;
    end else begin
      if (ev) void'(model.pop_front());
      if (ps) begin
        model.push_front(d);
        if (model.size() > DEPTH) void'(model.pop_back());
      end
    end
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0;
    model.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(1'b0, 1'b1, 12'h5A5, "R1");
    step(1'b0, 1'b0, 12'h000, "R8");
  endtask

  task automatic t_lifo();
    do_reset();
    step(1'b1, 1'b0, 12'h123, "R2");
    step(1'b1, 1'b0, 12'h456, "R2");
    step(1'b1, 1'b0, 12'hFED, "R2");
    step(1'b0, 1'b0, 12'h000, "R5");
    step(1'b0, 1'b1, 12'h000, "R2");
    step(1'b0, 1'b1, 12'h000, "R2");
    step(1'b1, 1'b0, 12'h0F0, "R2");
    step(1'b0, 1'b1, 12'h000, "R2");
    step(1'b0, 1'b1, 12'h000, "R2");
    step(1'b0, 1'b1, 12'h000, "R5");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 12'(12'h100 + i * 12'h011), "R4");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 12'h000, "R4");
    step(1'b0, 1'b1, 12'h000, "R3");
  endtask

  task automatic t_underflow();
    do_reset();
    step(1'b1, 1'b0, 12'hABC, "R3");
    step(1'b0, 1'b1, 12'h000, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 12'h000, "R3");
    step(1'b1, 1'b0, 12'h777, "R3");
    step(1'b0, 1'b1, 12'h000, "R3");
    step(1'b0, 1'b1, 12'h000, "R8");
    step(1'b0, 1'b1, 12'h000, "R3");
  endtask

  task automatic t_swap();
    do_reset();
    step(1'b1, 1'b0, 12'h011, "R6");
    step(1'b1, 1'b0, 12'h022, "R6");
    step(1'b1, 1'b1, 12'h033, "R6");
    step(1'b0, 1'b1, 12'h000, "R6");
    step(1'b0, 1'b1, 12'h000, "R6");
    step(1'b0, 1'b1, 12'h000, "R6");
  endtask

  task automatic t_swap_empty();
    do_reset();
    step(1'b1, 1'b1, 12'h9C3, "R7");
    step(1'b0, 1'b1, 12'h000, "R7");
    step(1'b0, 1'b1, 12'h000, "R7");
  endtask

  task automatic t_swap_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 12'(12'h200 + i), "R6");
    step(1'b1, 1'b1, 12'h3FF, "R6");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 12'h000, "R6");
    step(1'b0, 1'b1, 12'h000, "R9");
  endtask

  task automatic t_mid_reset();
    do_reset();
    step(1'b1, 1'b0, 12'h444, "R1");
    step(1'b1, 1'b0, 12'h555, "R1");
    do_reset();
    step(1'b0, 1'b1, 12'h000, "R1");
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_overflow();
    t_underflow();
    t_swap();
    t_swap_empty();
    t_swap_full();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule